// File: doc/BRIEF.md
# Paged DMA Address Generator

This block produces the 24-bit memory address for one legacy-compatible DMA channel. The address combines an 8-bit page register with a 16-bit current-address counter. A load strobe captures the page, the starting counter value, the transfer count, the direction and the transfer width. From then on, each step strobe moves the counter by one position and lowers the remaining count by one.

The counter never carries into the page register and never borrows from it. In byte mode the address wraps inside a 64 KiB window. In word mode the counter is shifted left by one bit and page bit 0 is dropped, so the address wraps inside a 128 KiB window and is always even. To reach an even target address in word mode, software loads the counter with that address shifted right by one. The count register holds bytes in byte mode and 16-bit words in word mode. A terminal flag rises when a step takes the count below zero.

Top module: `pdma_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `addr_o` is 000000h, `count_o` is 0000h and `tc_o` is 0. The channel starts in byte mode with increment.
- R2: A cycle with `load_i`=1 captures `page_i`, `base_i`, `count_i`, `dir_dec_i` and `word_mode_i`, and clears `tc_o`. The outputs show the new values from the next clock edge.
- R3: In byte mode (`word_mode_i`=0 at load) with increment (`dir_dec_i`=0 at load), each step adds 1 to `addr_o[15:0]`. `addr_o[23:16]` stays unchanged, so 01FFFFh steps to 010000h.
- R4: In byte mode with decrement (`dir_dec_i`=1), each step subtracts 1 inside the same 64 KiB page, so 020000h steps to 02FFFFh.
- R5: In word mode, `addr_o` = {page[7:1], counter[15:0], 1'b0}. Page bit 0 has no effect and `addr_o[0]` is always 0.
- R6: In word mode with increment, the counter wraps inside the 128 KiB page. Page 01h with counter FFFFh gives 01FFFEh, and one step then gives 000000h.
- R7: In word mode with decrement, page 02h with counter 0000h gives 020000h, and one step then gives 03FFFEh.
- R8: Each step lowers `count_o` by exactly 1, in both modes.
- R9: A step taken while `count_o` is 0000h wraps the count to FFFFh and sets `tc_o` from the next edge. `tc_o` stays set until the next load.
- R10: In a cycle with neither load nor step, `addr_o`, `count_o` and `tc_o` hold their values.
- R11: When `load_i` and `step_i` are both high in the same cycle, the load takes effect and the step is discarded.
- R12: Direction and width are taken only at load. Changing `dir_dec_i` or `word_mode_i` between loads does not affect the steps that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture the page, base, count, direction and width |
| step_i | input | 1 | One transfer cycle completed |
| page_i | input | 8 | Page register value |
| base_i | input | 16 | Start value of the current-address counter |
| count_i | input | 16 | Start value of the transfer count |
| dir_dec_i | input | 1 | 1 = decrement, 0 = increment |
| word_mode_i | input | 1 | 1 = 16-bit words with shifted address, 0 = bytes |
| addr_o | output | 24 | Memory address |
| count_o | output | 16 | Remaining transfer count |
| tc_o | output | 1 | Count has stepped past zero |

## Verification
The counter is driven with four pattern types: starts in the middle of a page, starts at the top of a page while incrementing, starts at the bottom of a page while decrementing, and word-mode loads with both odd and even page values. Mid-page stepping shows that the counter moves in the correct direction. The edge-of-page starts show that the counter wraps inside its page instead of carrying into the page register. The odd-page word loads show that page bit 0 is dropped. Separate sequences cover a count run down through zero, a load and a step in the same cycle, and changing the direction and width inputs between loads.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic {
    XFER_BYTE = 1'b0,
    XFER_WORD = 1'b1
  } xfer_mode_e;

  typedef enum logic {
    DIR_INC = 1'b0,
    DIR_DEC = 1'b1
  } step_dir_e;
endpackage

// File: rtl/pdma_addr_ctr.sv
module pdma_addr_ctr #(
  parameter int W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  pdma_pkg::step_dir_e dir_i,
  input  logic [W-1:0]     load_val_i,
  output logic [W-1:0]     val_o
);
  logic [W-1:0] nxt;

  // wraps modulo 2^W: never touches the page
  always_comb begin
    if (dir_i == pdma_pkg::DIR_DEC) nxt = val_o - W'(1);
    else                            nxt = val_o + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_o <= '0;
    else if (load_i) val_o <= load_val_i;
    else if (step_i) val_o <= nxt;
  end
endmodule

// File: rtl/pdma_count.sv
module pdma_count #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         tc_o
);
  logic at_zero;
  assign at_zero = (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      tc_o  <= 1'b0;
    end else if (load_i) begin
      cnt_o <= load_val_i;
      tc_o  <= 1'b0;
    end else if (step_i) begin
      cnt_o <= cnt_o - W'(1);
      if (at_zero) tc_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pdma_addr_map.sv
module pdma_addr_map #(
  parameter int PAGE_W = 8,
  parameter int CTR_W  = 16,
  localparam int ADDR_W = PAGE_W + CTR_W
) (
  input  pdma_pkg::xfer_mode_e mode_i,
  input  logic [PAGE_W-1:0]    page_i,
  input  logic [CTR_W-1:0]     ctr_i,
  output logic [ADDR_W-1:0]    addr_o
);
  logic [ADDR_W-1:0] byte_addr, word_addr;

  assign byte_addr = {page_i, ctr_i};
  // word mode: page LSB dropped, counter shifted up by one
  assign word_addr = {page_i[PAGE_W-1:1], ctr_i, 1'b0};

  always_comb begin
    if (mode_i == pdma_pkg::XFER_WORD) addr_o = word_addr;
    else                               addr_o = byte_addr;
  end
endmodule

// File: rtl/pdma_addr_gen.sv
module pdma_addr_gen #(
  parameter int PAGE_W = 8,
  parameter int CTR_W  = 16,
  parameter int CNT_W  = 16,
  localparam int ADDR_W = PAGE_W + CTR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [CTR_W-1:0]  base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              dir_dec_i,
  input  logic              word_mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              tc_o
);
  import pdma_pkg::*;

  logic [PAGE_W-1:0] page_q;
  logic [CTR_W-1:0]  ctr_q;
  xfer_mode_e        mode_q;
  step_dir_e         dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      mode_q <= XFER_BYTE;
      dir_q  <= DIR_INC;
    end else if (load_i) begin
      page_q <= page_i;
      mode_q <= xfer_mode_e'(word_mode_i);
      dir_q  <= step_dir_e'(dir_dec_i);
    end
  end

  pdma_addr_ctr #(.W(CTR_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .step_i     (step_i),
    .dir_i      (dir_q),
    .load_val_i (base_i),
    .val_o      (ctr_q)
  );

  pdma_count #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .step_i     (step_i),
    .load_val_i (count_i),
    .cnt_o      (count_o),
    .tc_o       (tc_o)
  );

  pdma_addr_map #(.PAGE_W(PAGE_W), .CTR_W(CTR_W)) u_map (
    .mode_i (mode_q),
    .page_i (page_q),
    .ctr_i  (ctr_q),
    .addr_o (addr_o)
  );
endmodule

// File: rtl/pdma_addr_gen_chk.sv
module pdma_addr_gen_chk #(
  parameter int PAGE_W = 8,
  parameter int CTR_W  = 16,
  parameter int CNT_W  = 16,
  localparam int ADDR_W = PAGE_W + CTR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              step_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              word_q_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              tc_o
);
  a_r2_load_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_o == $past(count_i)) && !tc_o);

  a_r8_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> count_o == CNT_W'($past(count_o) - CNT_W'(1)));

  a_r9_tc_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && count_o == '0) |=> tc_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(addr_o) && $stable(count_o) && $stable(tc_o));

  // R3/R4: byte-mode step keeps the page bits
  a_r3_page_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !word_q_i) |=>
      addr_o[ADDR_W-1:CTR_W] == $past(addr_o[ADDR_W-1:CTR_W]));

  a_r5_word_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_q_i |-> !addr_o[0]);
endmodule

bind pdma_addr_gen pdma_addr_gen_chk #(
  .PAGE_W(PAGE_W), .CTR_W(CTR_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_i   (load_i),
  .step_i   (step_i),
  .count_i  (count_i),
  .word_q_i (mode_q == pdma_pkg::XFER_WORD),
  .addr_o   (addr_o),
  .count_o  (count_o),
  .tc_o     (tc_o)
);

// File: tb/pdma_addr_gen_bench.sv
module pdma_addr_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0, step_i = 1'b0;
  logic [7:0]  page_i = '0;
  logic [15:0] base_i = '0, count_i = '0;
  logic        dir_dec_i = 1'b0, word_mode_i = 1'b0;
  logic [23:0] addr_o;
  logic [15:0] count_o;
  logic        tc_o;

  int n_tests = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  pdma_addr_gen u_pdma_addr_gen (
    .clk_i, .rst_ni, .load_i, .step_i, .page_i, .base_i, .count_i,
    .dir_dec_i, .word_mode_i, .addr_o, .count_o, .tc_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_addr(input logic [7:0] pg, input logic [15:0] c,
                                           input logic w);
    return w ? {pg[7:1], c, 1'b0} : {pg, c};
  endfunction

  task automatic do_load(input logic [7:0] pg, input logic [15:0] b, input logic [15:0] n,
                         input logic dec, input logic w);
    @(negedge clk_i);
    load_i = 1'b1; page_i = pg; base_i = b; count_i = n; dir_dec_i = dec; word_mode_i = w;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic do_step();
    @(negedge clk_i);
    step_i = 1'b1;
    @(negedge clk_i);
    step_i = 1'b0;
  endtask

  task automatic t_reset();
    #2;
    chk("R1 addr in reset", 32'(addr_o), 0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 addr", 32'(addr_o), 0);
    chk("R1 count", 32'(count_o), 0);
    chk("R1 tc", 32'(tc_o), 0);
  endtask

  task automatic t_load();
    do_load(8'h3C, 16'h1234, 16'h0005, 1'b0, 1'b0);
    chk("R2 addr", 32'(addr_o), 32'h3C1234);
    chk("R2 count", 32'(count_o), 5);
    chk("R2 tc", 32'(tc_o), 0);
  endtask

  task automatic t_byte_inc();
    do_load(8'h01, 16'hFFFE, 16'h0010, 1'b0, 1'b0);
    do_step();
    chk("R3 mid step", 32'(addr_o), 32'h01FFFF);
    do_step();
    chk("R3 wrap in page", 32'(addr_o), 32'h010000);
    chk("R8 byte count", 32'(count_o), 16'h000E);
  endtask

  task automatic t_byte_dec();
    do_load(8'h02, 16'h0001, 16'h0010, 1'b1, 1'b0);
    do_step();
    chk("R4 mid step", 32'(addr_o), 32'h020000);
    do_step();
    chk("R4 wrap in page", 32'(addr_o), 32'h02FFFF);
  endtask

  task automatic t_word_map();
    do_load(8'hA5, 16'h4321, 16'h0003, 1'b0, 1'b1);
    chk("R5 odd page", 32'(addr_o), 32'(exp_addr(8'hA5, 16'h4321, 1'b1)));
    do_load(8'hA4, 16'h4321, 16'h0003, 1'b0, 1'b1);
    chk("R5 even page same addr", 32'(addr_o), 32'hA48642);
    do_step();
    chk("R5 step by one word", 32'(addr_o), 32'hA48644);
    chk("R8 word count", 32'(count_o), 2);
  endtask

  task automatic t_word_inc();
    do_load(8'h01, 16'hFFFF, 16'h0004, 1'b0, 1'b1);
    chk("R6 start", 32'(addr_o), 32'h01FFFE);
    do_step();
    chk("R6 wrap 128K", 32'(addr_o), 32'h000000);
  endtask

  task automatic t_word_dec();
    do_load(8'h02, 16'h0000, 16'h0004, 1'b1, 1'b1);
    chk("R7 start", 32'(addr_o), 32'h020000);
    do_step();
    chk("R7 wrap 128K", 32'(addr_o), 32'h03FFFE);
  endtask

  task automatic t_tc();
    do_load(8'h10, 16'h0000, 16'h0001, 1'b0, 1'b0);
    do_step();
    chk("R9 not yet", 32'(tc_o), 0);
    chk("R9 count zero", 32'(count_o), 0);
    do_step();
    chk("R9 tc set", 32'(tc_o), 1);
    chk("R9 count wraps", 32'(count_o), 16'hFFFF);
    do_step();
    chk("R9 tc sticky", 32'(tc_o), 1);
    do_load(8'h10, 16'h0000, 16'h0001, 1'b0, 1'b0);
    chk("R9 tc cleared by load", 32'(tc_o), 0);
  endtask

  task automatic t_hold();
    do_load(8'h55, 16'h0100, 16'h0009, 1'b0, 1'b0);
    repeat (3) @(negedge clk_i);
    chk("R10 addr held", 32'(addr_o), 32'h550100);
    chk("R10 count held", 32'(count_o), 9);
  endtask

  task automatic t_load_prio();
    @(negedge clk_i);
    load_i = 1'b1; step_i = 1'b1; page_i = 8'h77; base_i = 16'h8000; count_i = 16'h0020;
    dir_dec_i = 1'b0; word_mode_i = 1'b0;
    @(negedge clk_i);
    load_i = 1'b0; step_i = 1'b0;
    chk("R11 addr", 32'(addr_o), 32'h778000);
    chk("R11 count", 32'(count_o), 16'h0020);
  endtask

  task automatic t_mode_capture();
    do_load(8'h12, 16'h0010, 16'h0008, 1'b0, 1'b0);
    @(negedge clk_i);
    dir_dec_i = 1'b1; word_mode_i = 1'b1;
    do_step();
    chk("R12 byte inc kept", 32'(addr_o), 32'h120011);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_load();
        t_byte_inc();
        t_byte_dec();
        t_word_map();
        t_word_inc();
        t_word_dec();
        t_tc();
        t_hold();
        t_load_prio();
        t_mode_capture();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule